// File: doc/BRIEF.md
# Dual-Slot In-Order Dispatch Unit

This block sits between the instruction queue and the execution back end. Every cycle it looks at the two oldest queue slots, called slot 0 and slot 1, and decides whether none, one or both of them leave the queue. Slot 0 is always the older one. A slot leaves only if every resource it needs is free: its target execution unit, a rename register when it writes one, and a completion-queue entry. Serialization can also hold a slot back.

There are two kinds of branch. A branch that writes neither the link register nor the count register is dropped from the queue. It uses no completion entry and no unit. A branch that writes either of those registers takes a completion entry only. For each cycle the block drives one issue strobe per execution unit and a count of completion entries to allocate. It also drives how far the queue shifts, and a dropped branch counts in that shift.

Serialization is handled by a two-state controller. In **RUN**, dispatch is evaluated normally. The transition **RUN→HOLD** happens when slot 0 holds a serializing instruction and the completion queue is not empty. In **HOLD**, nothing dispatches. The transition **HOLD→RUN** happens on the edge after the completion queue reports itself fully free. Back in RUN, the serializing instruction can then dispatch, and it goes alone.

Top module: `dispatch_pair`

Class codes on `iqN_cls`: 0 integer unit, 1 load/store unit, 2 floating-point unit, 3 system unit, 4 dropped branch, 5 link/count branch. Codes 6 and 7 behave like 4. For codes 0 to 3, `unit_issue` bit k strobes the unit with class code k.

## Requirements
- R1: While `rst` is high, `unit_issue`, `cq_alloc` and `iq_shift` are all zero, and the controller leaves reset in RUN.
- R2: Slot 1 never leaves the queue unless slot 0 leaves in the same cycle. An invalid slot 0 means a shift of zero.
- R3: A unit-class instruction in slot 0 dispatches only when all three of these hold: its unit's `unit_idle` bit is set, `ren_free` is at least 1 if its rename flag is set, and `cq_free` is at least 1.
- R4: Slot 1 joins slot 0 only if `cq_free` covers the completion entries of both slots together and `ren_free` covers the renames of both slots together.
- R5: If both slots target the same execution unit, only slot 0 issues.
- R6: A dropped-branch class in either slot is consumed with no unit strobe and no completion entry, and it needs no resource at all.
- R7: A link/count branch needs one completion entry. It strobes no unit and ignores its rename and serialize flags.
- R8: A serializing instruction in slot 0 dispatches only in RUN with `cq_free` equal to `CQ_DEPTH`, and slot 1 stays put in that cycle.
- R9: A serializing instruction in slot 0 with `cq_free` below `CQ_DEPTH` dispatches nothing and moves the controller to HOLD. HOLD dispatches nothing, and it returns to RUN on the edge after `cq_free` equals `CQ_DEPTH`.
- R10: A serializing instruction in slot 1 never dispatches alongside slot 0.
- R11: `iq_shift` equals the number of slots consumed, dropped branches included. `cq_alloc` equals the number of consumed slots that take a completion entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iq0_valid | input | 1 | Slot 0 holds an instruction |
| iq0_cls | input | 3 | Slot 0 class code |
| iq0_ren | input | 1 | Slot 0 needs a rename register |
| iq0_ser | input | 1 | Slot 0 is serializing |
| iq1_valid | input | 1 | Slot 1 holds an instruction |
| iq1_cls | input | 3 | Slot 1 class code |
| iq1_ren | input | 1 | Slot 1 needs a rename register |
| iq1_ser | input | 1 | Slot 1 is serializing |
| unit_idle | input | 4 | Per-unit free flag, indexed by class code |
| ren_free | input | RW | Free rename registers |
| cq_free | input | CW | Free completion-queue entries |
| unit_issue | output | 4 | Per-unit issue strobe |
| cq_alloc | output | 2 | Completion entries allocated this cycle |
| iq_shift | output | 2 | Slots consumed this cycle |

## Verification
Two functions can coincide in one cycle: a branch being dropped and a real dispatch from the other slot. They are provoked by placing a dropped branch next to an integer instruction in both orders. In that cycle the shift must count both slots while `cq_alloc` and the strobes reflect only the dispatched instruction. A second coincidence is resource sharing between the two slots, provoked by giving the pair just enough entries or renames for one slot. It is judged by slot 0 going alone with a shift of one.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
    localparam int N_UNIT = 4;

    typedef enum logic [2:0] {
        CL_INT = 3'd0, CL_LSU = 3'd1, CL_FPU = 3'd2, CL_SYS = 3'd3,
        CL_BRF = 3'd4, CL_BRL = 3'd5, CL_RS6 = 3'd6, CL_RS7 = 3'd7
    } cls_e;

    typedef enum logic {ST_RUN = 1'b0, ST_HOLD = 1'b1} ctl_e;

    typedef struct packed {
        logic valid;
        cls_e cls;
        logic ren;
        logic ser;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic [N_UNIT-1:0] unit;
        logic              cq;
        logic              ren;
        logic              ser;
        logic              fold;
    } need_t;
endpackage

// File: rtl/dispatch_slot_eval.sv
module dispatch_slot_eval
    import dispatch_pkg::*;
(
    input  slot_t slot,
    output need_t need
);
    always_comb begin
        need       = '0;
        need.valid = slot.valid;
        unique case (slot.cls)
            CL_INT, CL_LSU, CL_FPU, CL_SYS: begin
                need.unit[slot.cls[1:0]] = 1'b1;
                need.cq  = 1'b1;
                need.ren = slot.ren;
                need.ser = slot.ser;
            end
            CL_BRL: need.cq = 1'b1;
            default: need.fold = 1'b1;
        endcase
    end
endmodule

// File: rtl/dispatch_pair_gate.sv
module dispatch_pair_gate
    import dispatch_pkg::*;
#(
    parameter int CQ_DEPTH = 5,
    parameter int CW       = 3,
    parameter int RW       = 3
) (
    input  need_t             n0,
    input  need_t             n1,
    input  logic              run,
    input  logic [N_UNIT-1:0] unit_idle,
    input  logic [RW-1:0]     ren_free,
    input  logic [CW-1:0]     cq_free,
    output logic              go0,
    output logic              go1,
    output logic              want_hold
);
    logic [CW-1:0] cq_need;
    logic [RW-1:0] ren_need;
    logic          cq_empty;
    logic          res0;
    logic          res1;

    always_comb begin
        cq_need  = CW'(n0.cq) + CW'(n1.cq);
        ren_need = RW'(n0.ren) + RW'(n1.ren);
        cq_empty = (cq_free == CW'(CQ_DEPTH));

        res0 = ((n0.unit & ~unit_idle) == '0)
             && (!n0.cq  || cq_free  != '0)
             && (!n0.ren || ren_free != '0)
             && (!n0.ser || cq_empty);
        go0  = run && n0.valid && (n0.fold || res0);

        res1 = ((n1.unit & ~unit_idle) == '0)
             && ((n1.unit & n0.unit) == '0)
             && (!n1.cq  || cq_free  >= cq_need)
             && (!n1.ren || ren_free >= ren_need);
        go1  = go0 && n1.valid && !n0.ser && !n1.ser && (n1.fold || res1);

        want_hold = run && n0.valid && n0.ser && !cq_empty;
    end
endmodule

// File: rtl/dispatch_pair.sv
module dispatch_pair
    import dispatch_pkg::*;
#(
    parameter int CQ_DEPTH  = 5,
    parameter int REN_SLOTS = 6,
    parameter int CW        = $clog2(CQ_DEPTH + 1),
    parameter int RW        = $clog2(REN_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iq0_valid,
    input  logic [2:0]    iq0_cls,
    input  logic          iq0_ren,
    input  logic          iq0_ser,
    input  logic          iq1_valid,
    input  logic [2:0]    iq1_cls,
    input  logic          iq1_ren,
    input  logic          iq1_ser,
    input  logic [3:0]    unit_idle,
    input  logic [RW-1:0] ren_free,
    input  logic [CW-1:0] cq_free,
    output logic [3:0]    unit_issue,
    output logic [1:0]    cq_alloc,
    output logic [1:0]    iq_shift
);
    localparam logic [CW-1:0] CQ_ALL = CW'(CQ_DEPTH);

    ctl_e  state, state_nx;
    slot_t slots [2];
    need_t needs [2];
    logic  run, go0, go1, want_hold;

    assign slots[0] = '{valid: iq0_valid, cls: cls_e'(iq0_cls), ren: iq0_ren, ser: iq0_ser};
    assign slots[1] = '{valid: iq1_valid, cls: cls_e'(iq1_cls), ren: iq1_ren, ser: iq1_ser};

    for (genvar g = 0; g < 2; g++) begin : g_slot
        dispatch_slot_eval u_eval (.slot(slots[g]), .need(needs[g]));
    end

    assign run = (state == ST_RUN) && !rst;

    dispatch_pair_gate #(.CQ_DEPTH(CQ_DEPTH), .CW(CW), .RW(RW)) u_gate (
        .n0(needs[0]), .n1(needs[1]), .run(run), .unit_idle(unit_idle),
        .ren_free(ren_free), .cq_free(cq_free),
        .go0(go0), .go1(go1), .want_hold(want_hold)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (want_hold)        state_nx = ST_HOLD;
            ST_HOLD: if (cq_free == CQ_ALL) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        unit_issue = (go0 ? needs[0].unit : 4'b0) | (go1 ? needs[1].unit : 4'b0);
        cq_alloc   = 2'(go0 && needs[0].cq) + 2'(go1 && needs[1].cq);
        iq_shift   = 2'(go0) + 2'(go1);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> (unit_issue == 4'b0 && iq_shift == 2'd0 && cq_alloc == 2'd0));
    assert_no_overtake_R2: assert property (@(posedge clk) disable iff (rst)
        !iq0_valid |-> iq_shift == 2'd0);
    assert_unit_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (unit_issue & ~unit_idle) == 4'b0);
    assert_cq_cover_R4: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cq_alloc} <= (CW+1)'(cq_free));
    assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        state == ST_HOLD |-> iq_shift == 2'd0);
    assert_hold_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && cq_free == CQ_ALL) |=> state == ST_RUN);
    assert_alloc_bound_R11: assert property (@(posedge clk) disable iff (rst)
        cq_alloc <= iq_shift && 2'($countones(unit_issue)) <= iq_shift);
endmodule

// File: tb/tb_dispatch_pair.sv
module tb_dispatch_pair;
    localparam int TCLK = 10;
    localparam int NV   = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iq0_valid, iq0_ren, iq0_ser, iq1_valid, iq1_ren, iq1_ser;
    logic [2:0] iq0_cls, iq1_cls;
    logic [3:0] unit_idle;
    logic [2:0] ren_free, cq_free;
    logic [3:0] unit_issue;
    logic [1:0] cq_alloc, iq_shift;
    int total = 0;
    int bad   = 0;

    always #(TCLK/2) clk = ~clk;

    dispatch_pair dut (
        .clk(clk), .rst(rst),
        .iq0_valid(iq0_valid), .iq0_cls(iq0_cls), .iq0_ren(iq0_ren), .iq0_ser(iq0_ser),
        .iq1_valid(iq1_valid), .iq1_cls(iq1_cls), .iq1_ren(iq1_ren), .iq1_ser(iq1_ser),
        .unit_idle(unit_idle), .ren_free(ren_free), .cq_free(cq_free),
        .unit_issue(unit_issue), .cq_alloc(cq_alloc), .iq_shift(iq_shift)
    );

    // slot = {valid, cls[2:0], ren, ser}
    localparam logic [5:0] INTR = 6'b1_000_1_0, INTN = 6'b1_000_0_0, LSUR = 6'b1_001_1_0;
    localparam logic [5:0] FPUR = 6'b1_010_1_0, FPUS = 6'b1_010_0_1, SYSS = 6'b1_011_0_1;
    localparam logic [5:0] BRF = 6'b1_100_0_0, BRL = 6'b1_101_0_0, NONE = 6'b0;

    // {slot0, slot1, idle, ren_free, cq_free, exp_issue, exp_alloc, exp_shift}
    localparam logic [29:0] VEC [NV] = '{
        {INTR, LSUR, 4'b1111, 3'd7, 3'd5, 4'b0011, 2'd2, 2'd2},
        {INTR, INTR, 4'b1111, 3'd7, 3'd5, 4'b0001, 2'd1, 2'd1},
        {INTR, FPUR, 4'b1111, 3'd1, 3'd5, 4'b0001, 2'd1, 2'd1},
        {INTR, LSUR, 4'b1111, 3'd7, 3'd1, 4'b0001, 2'd1, 2'd1},
        {INTR, LSUR, 4'b1110, 3'd7, 3'd5, 4'b0000, 2'd0, 2'd0},
        {BRF,  INTR, 4'b1111, 3'd7, 3'd5, 4'b0001, 2'd1, 2'd2},
        {BRL,  BRL,  4'b1111, 3'd7, 3'd5, 4'b0000, 2'd2, 2'd2},
        {INTR, LSUR, 4'b1111, 3'd0, 3'd5, 4'b0000, 2'd0, 2'd0},
        {SYSS, INTR, 4'b1111, 3'd7, 3'd5, 4'b1000, 2'd1, 2'd1},
        {INTR, FPUS, 4'b1111, 3'd7, 3'd5, 4'b0001, 2'd1, 2'd1},
        {NONE, INTR, 4'b1111, 3'd7, 3'd5, 4'b0000, 2'd0, 2'd0},
        {INTR, BRF,  4'b1111, 3'd7, 3'd5, 4'b0001, 2'd1, 2'd2},
        {BRF,  BRF,  4'b0000, 3'd0, 3'd0, 4'b0000, 2'd0, 2'd2},
        {BRL,  NONE, 4'b1111, 3'd7, 3'd0, 4'b0000, 2'd0, 2'd0},
        {INTN, LSUR, 4'b1111, 3'd1, 3'd5, 4'b0011, 2'd2, 2'd2}
    };

    function automatic string row_req(int i);
        case (i)
            0, 14: return "R4 pair";
            1:     return "R5 same unit";
            2, 3:  return "R4 shared resource";
            4, 7:  return "R3 slot0 blocked";
            5, 11, 12: return "R6 dropped branch";
            6, 13: return "R7 link branch";
            8:     return "R8 serial empty";
            9:     return "R10 serial in slot1";
            default: return "R2 invalid slot0";
        endcase
    endfunction

    task automatic drive(input logic [5:0] s0, input logic [5:0] s1,
                         input logic [3:0] idle, input logic [2:0] rf, input logic [2:0] cf);
        {iq0_valid, iq0_cls, iq0_ren, iq0_ser} = s0;
        {iq1_valid, iq1_cls, iq1_ren, iq1_ser} = s1;
        unit_idle = idle; ren_free = rf; cq_free = cf;
    endtask

    task automatic check(input string req, input logic [3:0] ei,
                         input logic [1:0] ea, input logic [1:0] es);
        total++;
        if (unit_issue !== ei || cq_alloc !== ea || iq_shift !== es) begin
            bad++;
            $display("FAIL %s: issue=%b alloc=%0d shift=%0d expected issue=%b alloc=%0d shift=%0d",
                     req, unit_issue, cq_alloc, iq_shift, ei, ea, es);
        end
    endtask

    initial begin
        #(TCLK * 5000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        drive(INTR, LSUR, 4'b1111, 3'd7, 3'd5);
        @(negedge clk); #1;
        check("R1 reset outputs", 4'b0, 2'd0, 2'd0);
        @(negedge clk); rst = 1'b0; #1;
        check("R1 leaves reset in RUN", 4'b0011, 2'd2, 2'd2);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][29:24], VEC[i][23:18], VEC[i][17:14], VEC[i][13:11], VEC[i][10:8]);
            #1;
            check(row_req(i), VEC[i][7:4], VEC[i][3:2], VEC[i][1:0]);
        end

        // R9: serialize with busy completion queue -> HOLD
        @(negedge clk); drive(SYSS, INTR, 4'b1111, 3'd7, 3'd3); #1;
        check("R9 serial waits", 4'b0, 2'd0, 2'd0);
        @(negedge clk); drive(SYSS, INTR, 4'b1111, 3'd7, 3'd5); #1;
        check("R9 HOLD dispatches nothing", 4'b0, 2'd0, 2'd0);
        @(negedge clk); #1;
        check("R9 back to RUN, R8 alone", 4'b1000, 2'd1, 2'd1);
        // HOLD blocks a plain instruction too
        @(negedge clk); drive(SYSS, NONE, 4'b1111, 3'd7, 3'd4); #1;
        check("R9 enter HOLD", 4'b0, 2'd0, 2'd0);
        @(negedge clk); drive(INTR, LSUR, 4'b1111, 3'd7, 3'd4); #1;
        check("R9 HOLD blocks plain pair", 4'b0, 2'd0, 2'd0);
        @(negedge clk); drive(INTR, LSUR, 4'b1111, 3'd7, 3'd5); #1;
        check("R9 HOLD until edge", 4'b0, 2'd0, 2'd0);
        @(negedge clk); #1;
        check("R9 RUN again, R11 shift", 4'b0011, 2'd2, 2'd2);

        // R1: reset mid-run forces outputs to zero
        rst = 1'b1; #1;
        check("R1 reset asserted", 4'b0, 2'd0, 2'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule